// File: doc/BRIEF.md
# Descriptor-Data TX Stream Packer

This block sits between a transaction source and a PCI Express transmit core. The source hands it one whole packet per handshake: a 128-bit descriptor, up to `TP_MAXW` 64-bit payload words, a payload word count, a non-posted marker and an error marker. The packer turns each packet into a run of beats on one 75-bit valid/ready bus. Beat 1 carries the upper descriptor half and beat 2 the lower half. Any payload words follow one per beat. Side-band bits above the data field carry start, end and error flags.

The input side has a skid FIFO of `SKID_DEPTH` whole packets. The source may keep presenting packets for up to `SKID_MARGIN` cycles after `in_ready` falls, and the FIFO absorbs them. A throttle mask, `np_mask`, stops any non-posted packet from starting. A blocked non-posted packet at the FIFO head is moved into a one-entry holding slot, so that posted packets and completions queued behind it can go out first.

A single state machine does the sequencing. Its states are S_IDLE, S_DESC_HI, S_DESC_LO and S_PAYLOAD. Its transitions are:

- pick (S_IDLE to S_DESC_HI): a packet is taken from the holding slot or from the FIFO head.
- park (S_IDLE to S_IDLE): the FIFO head moves into the holding slot.
- hi_done (S_DESC_HI to S_DESC_LO).
- lo_done_nodata (S_DESC_LO to S_IDLE).
- lo_done_data (S_DESC_LO to S_PAYLOAD).
- word_next (S_PAYLOAD to S_PAYLOAD).
- word_last (S_PAYLOAD to S_IDLE).

Every transition out of a beat state needs `out_ready` high.

Top module: `tlp_beat_packer`

## Requirements
- R1: The first beat of a packet carries descriptor bits 127:64 on bus bits 63:0, and bus bit 73 (start) is 1 on that beat and 0 on every other beat.
- R2: The second beat carries descriptor bits 63:0 on bus bits 63:0.
- R3: After the descriptor, exactly `in_words` beats follow (0 to `TP_MAXW`), carrying payload words 0, 1, ... in order. Word k comes from `in_payload[64k+63:64k]`.
- R4: Bus bit 72 (end) is 1 only on the last beat of a packet. For a packet with no payload, that last beat is the second beat.
- R5: Bus bits 71:64 are always 0. Bus bit 74 equals the packet's `in_err` on every beat of that packet.
- R6: While `out_valid` is high and `out_ready` is low, the beat is held unchanged. No beat is lost or repeated, and packets leave in acceptance order except as R8 to R10 allow.
- R7: A packet is accepted on any cycle where `in_valid` is high and the FIFO is not full, whatever the state of `in_ready`. `in_ready` is high only while more than `SKID_MARGIN` FIFO entries are free.
- R8: While `np_mask` is 1, no packet with `in_np`=1 starts. Posted packets behind it still go out in their original order.
- R9: Once `np_mask` is 0, a packet waiting in the holding slot is started before any packet still in the FIFO.
- R10: At most one non-posted packet is held. A second non-posted packet that reaches the FIFO head while the slot is full and the mask is high waits there and blocks the packets behind it.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1. `out_data` is all zero whenever `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Source presents a packet |
| in_ready | output | 1 | Skid FIFO has more than SKID_MARGIN entries free |
| in_desc | input | 128 | Packet descriptor |
| in_payload | input | 256 | Payload words, word k at bits 64k+63:64k |
| in_words | input | 3 | Number of payload words, 0 to 4 |
| in_np | input | 1 | Packet is a non-posted request |
| in_err | input | 1 | Error marker carried on every beat |
| np_mask | input | 1 | Throttle: hold back non-posted packets |
| out_valid | output | 1 | Bus beat is valid |
| out_ready | input | 1 | Receiver takes the beat |
| out_data | output | 75 | Beat: data 63:0, zero 71:64, end 72, start 73, error 74 |

## Verification
The assertions take two things for granted about the source. First, it never drives `in_valid` high when the FIFO is full. Second, `in_words` never exceeds `TP_MAXW`. Both are also checked as assertions, so a source that breaks the skid contract is reported rather than silently dropping a packet.

The bench keeps within these limits. Its normal send task waits for `in_ready`. Its burst test presents exactly `SKID_MARGIN` further packets after it sees `in_ready` low. It only ever presents word counts from 0 to 4. `out_ready` is driven freely, including random stalls, because the block places no condition on the receiver.

// File: rtl/tlp_pack_pkg.sv
package tlp_pack_pkg;
    parameter int TP_DW     = 64;
    parameter int TP_DESC_W = 128;
    parameter int TP_MAXW   = 4;
    localparam int TP_LEN_W = $clog2(TP_MAXW + 1);
    localparam int TP_IDX_W = (TP_MAXW > 1) ? $clog2(TP_MAXW) : 1;
    localparam int TP_PAD_W = 8;
    localparam int TP_EOP   = TP_DW + TP_PAD_W;
    localparam int TP_SOP   = TP_EOP + 1;
    localparam int TP_ERR   = TP_SOP + 1;
    localparam int TP_BUS_W = TP_ERR + 1;

    typedef struct packed {
        logic [TP_DESC_W-1:0]     desc;
        logic [TP_MAXW*TP_DW-1:0] pay;
        logic [TP_LEN_W-1:0]      words;
        logic                     np;
        logic                     err;
    } pkt_t;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_DESC_HI = 2'd1,
        S_DESC_LO = 2'd2,
        S_PAYLOAD = 2'd3
    } seq_state_e;
endpackage

// File: rtl/tx_skid_fifo.sv
module tx_skid_fifo
    import tlp_pack_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int MARGIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_valid,
    input  pkt_t push_pkt,
    output logic push_ready,
    input  logic pop,
    output logic empty,
    output pkt_t head
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    pkt_t          mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;
    logic          full;
    logic          do_push;
    logic          do_pop;

    assign full       = (count == CW'(DEPTH));
    assign empty      = (count == '0);
    assign do_push    = push_valid && !full;
    assign do_pop     = pop && !empty;
    assign head       = mem[rd_ptr];
    assign push_ready = (CW'(DEPTH) - count) > CW'(MARGIN);

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_pkt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // Source contract: it stops before the storage runs out.
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid |-> !full);
    assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/np_hold_slot.sv
module np_hold_slot
    import tlp_pack_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  pkt_t load_pkt,
    input  logic take,
    output logic full,
    output pkt_t pkt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            pkt  <= '0;
        end else if (load) begin
            full <= 1'b1;
            pkt  <= load_pkt;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    assert_single_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !full);
    assert_take_when_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> full);
    assert_hold_is_np_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> load_pkt.np);
endmodule

// File: rtl/tx_beat_seq.sv
module tx_beat_seq
    import tlp_pack_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fifo_empty,
    input  pkt_t                fifo_head,
    output logic                fifo_pop,
    input  logic                hold_full,
    input  pkt_t                hold_pkt,
    output logic                hold_load,
    output logic                hold_take,
    input  logic                np_mask,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [TP_BUS_W-1:0] out_data
);
    seq_state_e          state, next_state;
    pkt_t                cur, next_cur;
    logic [TP_IDX_W-1:0] widx, next_widx;
    logic [TP_DW-1:0]    pay_w [TP_MAXW];
    logic                last_word;

    for (genvar g = 0; g < TP_MAXW; g++) begin : g_unpack
        assign pay_w[g] = cur.pay[g*TP_DW +: TP_DW];
    end

    assign last_word = (TP_LEN_W'(widx) + TP_LEN_W'(1)) == cur.words;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cur   <= '0;
            widx  <= '0;
        end else begin
            state <= next_state;
            cur   <= next_cur;
            widx  <= next_widx;
        end
    end

    // Transitions
    always_comb begin
        next_state = state;
        next_cur   = cur;
        next_widx  = widx;
        fifo_pop   = 1'b0;
        hold_load  = 1'b0;
        hold_take  = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (hold_full && !np_mask) begin
                    hold_take  = 1'b1;
                    next_cur   = hold_pkt;
                    next_state = S_DESC_HI;
                end else if (!fifo_empty) begin
                    if (fifo_head.np && np_mask) begin
                        if (!hold_full) begin
                            hold_load = 1'b1;
                            fifo_pop  = 1'b1;
                        end
                    end else begin
                        fifo_pop   = 1'b1;
                        next_cur   = fifo_head;
                        next_state = S_DESC_HI;
                    end
                end
            end
            S_DESC_HI: if (out_ready) next_state = S_DESC_LO;
            S_DESC_LO: begin
                if (out_ready) begin
                    next_widx  = '0;
                    next_state = (cur.words == '0) ? S_IDLE : S_PAYLOAD;
                end
            end
            S_PAYLOAD: begin
                if (out_ready) begin
                    if (last_word) next_state = S_IDLE;
                    else           next_widx  = widx + 1'b1;
                end
            end
            default: next_state = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        out_valid = 1'b0;
        out_data  = '0;
        unique case (state)
            S_DESC_HI: begin
                out_valid           = 1'b1;
                out_data[TP_DW-1:0] = cur.desc[TP_DESC_W-1 -: TP_DW];
                out_data[TP_SOP]    = 1'b1;
                out_data[TP_ERR]    = cur.err;
            end
            S_DESC_LO: begin
                out_valid           = 1'b1;
                out_data[TP_DW-1:0] = cur.desc[TP_DW-1:0];
                out_data[TP_EOP]    = (cur.words == '0);
                out_data[TP_ERR]    = cur.err;
            end
            S_PAYLOAD: begin
                out_valid           = 1'b1;
                out_data[TP_DW-1:0] = pay_w[widx];
                out_data[TP_EOP]    = last_word;
                out_data[TP_ERR]    = cur.err;
            end
            default: ;
        endcase
    end

    assert_np_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == S_IDLE && state == S_DESC_HI && cur.np) |-> !$past(np_mask));
    assert_payload_idx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PAYLOAD) |-> (TP_LEN_W'(widx) < cur.words));
endmodule

// File: rtl/tlp_beat_packer.sv
module tlp_beat_packer
    import tlp_pack_pkg::*;
#(
    parameter int SKID_DEPTH  = 8,
    parameter int SKID_MARGIN = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [TP_DESC_W-1:0]     in_desc,
    input  logic [TP_MAXW*TP_DW-1:0] in_payload,
    input  logic [TP_LEN_W-1:0]      in_words,
    input  logic                     in_np,
    input  logic                     in_err,
    input  logic                     np_mask,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [TP_BUS_W-1:0]      out_data
);
    pkt_t in_pkt;
    pkt_t head_pkt;
    pkt_t held_pkt;
    logic fifo_empty, fifo_pop;
    logic hold_full, hold_load, hold_take;

    assign in_pkt = '{desc: in_desc, pay: in_payload, words: in_words,
                      np: in_np, err: in_err};

    tx_skid_fifo #(.DEPTH(SKID_DEPTH), .MARGIN(SKID_MARGIN)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_valid(in_valid), .push_pkt(in_pkt), .push_ready(in_ready),
        .pop(fifo_pop), .empty(fifo_empty), .head(head_pkt)
    );

    np_hold_slot u_hold (
        .clk(clk), .rst_n(rst_n),
        .load(hold_load), .load_pkt(head_pkt), .take(hold_take),
        .full(hold_full), .pkt(held_pkt)
    );

    tx_beat_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .fifo_empty(fifo_empty), .fifo_head(head_pkt), .fifo_pop(fifo_pop),
        .hold_full(hold_full), .hold_pkt(held_pkt),
        .hold_load(hold_load), .hold_take(hold_take),
        .np_mask(np_mask),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    assert_pad_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_data[TP_EOP-1:TP_DW] == '0);
    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_data == '0));
    assert_desc_two_beats_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_data[TP_SOP] && out_data[TP_EOP]));
    assert_word_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (in_words <= TP_LEN_W'(TP_MAXW)));
endmodule

// File: tb/tlp_beat_packer_tb.sv
module tlp_beat_packer_tb;
    import tlp_pack_pkg::*;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     in_valid = 1'b0;
    logic                     in_ready;
    logic [TP_DESC_W-1:0]     in_desc = '0;
    logic [TP_MAXW*TP_DW-1:0] in_payload = '0;
    logic [TP_LEN_W-1:0]      in_words = '0;
    logic                     in_np = 1'b0;
    logic                     in_err = 1'b0;
    logic                     np_mask = 1'b0;
    logic                     out_valid;
    logic                     out_ready;
    logic [TP_BUS_W-1:0]      out_data;

    int checks = 0;
    int fails  = 0;
    logic [TP_BUS_W-1:0] exp_q [$];
    string               tag_q [$];
    logic       rand_rdy = 1'b0;
    logic       rdy_hold = 1'b1;
    logic [7:0] lfsr = 8'h5B;
    logic       prev_stall = 1'b0;
    logic [TP_BUS_W-1:0] prev_data = '0;

    always #2 clk = ~clk;

    tlp_beat_packer u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_desc(in_desc), .in_payload(in_payload), .in_words(in_words),
        .in_np(in_np), .in_err(in_err), .np_mask(np_mask),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    always @(posedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    assign out_ready = rand_rdy ? lfsr[0] : rdy_hold;

    // Stimulus table: {random stall, np, err, words[2:0], seed[15:0]}
    localparam logic [21:0] VEC [0:7] = '{
        {1'b0, 1'b0, 1'b0, 3'd0, 16'h0101},
        {1'b0, 1'b0, 1'b0, 3'd1, 16'h0202},
        {1'b0, 1'b1, 1'b1, 3'd0, 16'h0303},
        {1'b1, 1'b0, 1'b0, 3'd4, 16'h0404},
        {1'b1, 1'b0, 1'b1, 3'd2, 16'h0505},
        {1'b0, 1'b0, 1'b0, 3'd3, 16'h0606},
        {1'b1, 1'b1, 1'b0, 3'd1, 16'h0707},
        {1'b1, 1'b0, 1'b1, 3'd4, 16'h0808}
    };

    function automatic logic [TP_DESC_W-1:0] mk_desc(input logic [15:0] s);
        return {s, 16'h1111, ~s, 16'h2222, s ^ 16'h0F0F, 16'h3333, s, 16'h4444};
    endfunction

    function automatic logic [TP_DW-1:0] mk_word(input logic [15:0] s, input int k);
        return {s, 16'hA5A5 ^ 16'(k), ~s, 16'(k + 1)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [TP_BUS_W-1:0] act,
                         input logic [TP_BUS_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_pkt(input logic [15:0] s, input int words, input bit err);
        logic [TP_DESC_W-1:0] d;
        logic [TP_BUS_W-1:0]  b;
        d = mk_desc(s);
        b = '0; b[63:0] = d[127:64]; b[73] = 1'b1; b[74] = err;
        exp_q.push_back(b); tag_q.push_back("R1");
        b = '0; b[63:0] = d[63:0]; b[72] = (words == 0); b[74] = err;
        exp_q.push_back(b); tag_q.push_back("R2/R4");
        for (int k = 0; k < words; k++) begin
            b = '0; b[63:0] = mk_word(s, k); b[72] = (k == words - 1); b[74] = err;
            exp_q.push_back(b); tag_q.push_back("R3/R4/R5");
        end
    endtask

    task automatic load_inputs(input logic [15:0] s, input int words, input bit np, input bit err);
        in_desc = mk_desc(s);
        for (int k = 0; k < TP_MAXW; k++) in_payload[k*TP_DW +: TP_DW] = mk_word(s, k);
        in_words = TP_LEN_W'(words);
        in_np = np;
        in_err = err;
    endtask

    task automatic send_pkt(input logic [15:0] s, input int words, input bit np, input bit err);
        while (!in_ready) begin @(posedge clk); #1; end
        load_inputs(s, words, np, err);
        in_valid = 1'b1;
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic wait_drain();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 5000) begin @(negedge clk); guard++; end
        check(exp_q.size() == 0, "R6 drain", TP_BUS_W'(exp_q.size()), '0);
    endtask

    // Monitor: compare every transferred beat, check holding under stall
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall)
                check(out_valid && out_data == prev_data, "R6 hold", out_data, prev_data);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected beat", out_data, '0);
                end else begin
                    check(out_data == exp_q[0], tag_q[0], out_data, exp_q[0]);
                    void'(exp_q.pop_front());
                    void'(tag_q.pop_front());
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(out_valid == 1'b0, "R11 valid", TP_BUS_W'(out_valid), '0);
        check(out_data == '0, "R11 data", out_data, '0);
        check(in_ready == 1'b1, "R11 in_ready", TP_BUS_W'(in_ready), 1);
        @(posedge clk); #1;

        // Table walk (R1..R6)
        for (int i = 0; i < 8; i++) begin
            rand_rdy = VEC[i][21];
            expect_pkt(VEC[i][15:0], int'(VEC[i][18:16]), VEC[i][19]);
            send_pkt(VEC[i][15:0], int'(VEC[i][18:16]), VEC[i][20], VEC[i][19]);
        end
        wait_drain();
        rand_rdy = 1'b0; rdy_hold = 1'b1;

        // R8: masked non-posted packet is bypassed by posted ones
        np_mask = 1'b1;
        send_pkt(16'hA001, 2, 1'b1, 1'b0);
        expect_pkt(16'hA002, 1, 1'b0); send_pkt(16'hA002, 1, 1'b0, 1'b0);
        expect_pkt(16'hA003, 0, 1'b1); send_pkt(16'hA003, 0, 1'b0, 1'b1);
        wait_drain();
        repeat (20) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R8 np stays held", TP_BUS_W'(out_valid), '0);
        // R9: release on mask low
        expect_pkt(16'hA001, 2, 1'b0);
        @(posedge clk); #1 np_mask = 1'b0;
        wait_drain();

        // R10: second np waits at the head and blocks later packets
        np_mask = 1'b1;
        send_pkt(16'hB001, 1, 1'b1, 1'b0);
        send_pkt(16'hB002, 0, 1'b1, 1'b1);
        send_pkt(16'hB003, 3, 1'b0, 1'b0);
        repeat (20) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R10 blocked behind second np", TP_BUS_W'(out_valid), '0);
        expect_pkt(16'hB001, 1, 1'b0);   // R9 held packet first
        expect_pkt(16'hB002, 0, 1'b1);
        expect_pkt(16'hB003, 3, 1'b0);
        @(posedge clk); #1 np_mask = 1'b0;
        wait_drain();

        // R7: skid burst with receiver stalled
        begin
            int n = 0;
            int extra = 0;
            rdy_hold = 1'b0;
            @(posedge clk); #1;
            while (extra < 3) begin
                if (!in_ready) extra++;
                load_inputs(16'hC000 + 16'(n), n % 3, 1'b0, 1'b0);
                expect_pkt(16'hC000 + 16'(n), n % 3, 1'b0);
                in_valid = 1'b1;
                n++;
                @(posedge clk); #1;
            end
            in_valid = 1'b0;
            @(negedge clk);
            check(in_ready == 1'b0, "R7 ready low when full", TP_BUS_W'(in_ready), '0);
            check(n == 9, "R7 packets before stop", TP_BUS_W'(n), 9);
            @(posedge clk); #1 rdy_hold = 1'b1;
            wait_drain();
            @(negedge clk);
            check(in_ready == 1'b1, "R7 ready back", TP_BUS_W'(in_ready), 1);
            check(out_data == '0 && !out_valid, "R11 idle zero", out_data, '0);
        end

        summary();
        $finish;
    end
endmodule